// File: doc/BRIEF.md
# Tagged Waveform Readout Engine

The engine moves a finished waveform record from local sample memory to a host over a parallel bus. When the capture side signals that a record is complete, the engine raises a request to the host. It then waits until the host accepts. After that it reads every stored sample, channel by channel. For each sample it sends one self-describing 25-bit word that carries the channel number, the sample index, the converted value, an over-range flag and an even parity bit. One word leaves per clock cycle, marked by a valid strobe.

Several front-end modules share one host bus. For that reason the engine raises a bus-enable line only while it owns the bus, and it holds the word lines at zero whenever no word is valid. The enable controls the three-state pad drivers at the chip edge. When the last word has left, the engine drops its request and gives a one-cycle completion pulse, which re-arms the capture side. Sample memory sits outside the block. It is a synchronous read port with one cycle of latency, and it returns a data value and an over-range flag for each address.

Top module: `rdo_engine`

## Requirements
- R1: While reset is held, and in the first cycle after it, host_req_o, word_valid_o, bus_oe_o, readout_done_o and mem_rd_en_o are low and host_word_o is zero.
- R2: When capture_done_i is sampled high while the engine is idle, host_req_o is high from the next cycle on. It stays high without a break until the cycle of the completion pulse, and it falls in that cycle.
- R3: host_accept_i has no effect unless a request is pending. While the request waits for acceptance, bus_oe_o, word_valid_o and mem_rd_en_o stay low.
- R4: When host_accept_i is sampled high with a request pending at clock edge E, bus_oe_o is high in the cycle after E. The first word is valid in the cycle after edge E+2.
- R5: Words come out in consecutive cycles with no gaps, in channel-major order. All NUM_SAMP samples of channel 0 come first, then channel 1, and so on up to channel NUM_CH-1. That makes NUM_CH*NUM_SAMP words in total.
- R6: Word layout: bit 24 is the over-range flag, bits 23:21 are the channel, bits 20:11 are the sample index and bits 10:1 are the sample value.
- R7: Bit 0 makes the count of ones across all 25 bits even.
- R8: Bit 24 equals the over-range flag that memory returned for that channel and sample.
- R9: For each word, memory is read at address {channel, sample} (channel in bits 12:10), one cycle before that read's data is used.
- R10: bus_oe_o is high only from the cycle after acceptance until the cycle that shows the last word. Whenever word_valid_o is low, host_word_o is all zeros.
- R11: In the cycle after the last word, word_valid_o and bus_oe_o are low and readout_done_o is high for exactly one cycle. After that the engine is idle again and a new capture_done_i starts a new request.
- R12: capture_done_i and host_accept_i pulses during a transfer are ignored. No new request follows the completion pulse unless capture_done_i is raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| capture_done_i | input | 1 | Record complete, start a readout |
| host_accept_i | input | 1 | Host grants the bus to this module |
| mem_rd_en_o | output | 1 | Sample memory read enable |
| mem_rd_addr_o | output | 13 | Read address {channel, sample} |
| mem_rd_data_i | input | 10 | Sample value, one cycle after the read |
| mem_rd_err_i | input | 1 | Over-range flag of the sample read |
| host_req_o | output | 1 | Request to the host |
| word_valid_o | output | 1 | host_word_o carries a word this cycle |
| host_word_o | output | 25 | Tagged word, zero when not valid |
| bus_oe_o | output | 1 | Enable for the shared-bus pad drivers |
| readout_done_o | output | 1 | One-cycle completion pulse |

## Verification
A walk counter that skips or repeats a step shows up as a wrong channel or sample tag in the very next word. A pipeline tag that is out of step with memory shows up as a mismatched value or over-range flag in the first word. A control state stuck in transfer shows up one cycle after the last word: the request and bus enable stay high and no completion pulse appears. A state that leaves the wait early shows up as the bus enable rising before any accept. Every word is compared against a value computed from the requirements. The bus lines and handshake are checked in every cycle around each readout.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

    localparam int CH_W   = 3;
    localparam int SAMP_W = 10;
    localparam int DATA_W = 10;
    localparam int ADDR_W = CH_W + SAMP_W;
    localparam int WORD_W = 1 + CH_W + SAMP_W + DATA_W + 1;

    typedef struct packed {
        logic              err;
        logic [CH_W-1:0]   ch;
        logic [SAMP_W-1:0] samp;
        logic [DATA_W-1:0] data;
        logic              par;
    } host_word_t;

    typedef struct packed {
        logic              vld;
        logic              last;
        logic [CH_W-1:0]   ch;
        logic [SAMP_W-1:0] samp;
    } rd_tag_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_XFER  = 3'd2,
        ST_FLUSH = 3'd3,
        ST_DONE  = 3'd4
    } rdo_state_t;

    function automatic host_word_t make_word(
        input logic              err,
        input logic [CH_W-1:0]   ch,
        input logic [SAMP_W-1:0] samp,
        input logic [DATA_W-1:0] data
    );
        host_word_t w;
        w.err  = err;
        w.ch   = ch;
        w.samp = samp;
        w.data = data;
        w.par  = ^{err, ch, samp, data};
        return w;
    endfunction

endpackage

// File: rtl/rdo_ctrl.sv
module rdo_ctrl
    import rdo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic capture_done_i,
    input  logic host_accept_i,
    input  logic issue_last_i,
    input  logic out_last_i,
    output logic issue_o,
    output logic req_o,
    output logic oe_o,
    output logic done_o
);

    rdo_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (capture_done_i) state_d = ST_REQ;
            ST_REQ:   if (host_accept_i)  state_d = ST_XFER;
            ST_XFER:  if (issue_last_i)   state_d = ST_FLUSH;
            ST_FLUSH: if (out_last_i)     state_d = ST_DONE;
            ST_DONE:                      state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign issue_o = (state_q == ST_XFER);
    assign oe_o    = (state_q == ST_XFER) || (state_q == ST_FLUSH);
    assign req_o   = (state_q == ST_REQ) || oe_o;
    assign done_o  = (state_q == ST_DONE);

    // R3: a waiting request never jumps to the bus without an accept
    assert_wait_for_accept_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REQ && !host_accept_i) |=> !oe_o);

    // R11: the completion state always returns to idle
    assert_done_to_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/rdo_addr.sv
module rdo_addr
    import rdo_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int NUM_SAMP = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              issue_last_o,
    output rd_tag_t           tag_o
);

    localparam logic [CH_W-1:0]   CH_LAST   = CH_W'(NUM_CH - 1);
    localparam logic [SAMP_W-1:0] SAMP_LAST = SAMP_W'(NUM_SAMP - 1);

    logic [CH_W-1:0]   ch_q;
    logic [SAMP_W-1:0] samp_q;
    logic              samp_wrap;
    logic              at_end;

    assign samp_wrap    = (samp_q == SAMP_LAST);
    assign at_end       = samp_wrap && (ch_q == CH_LAST);
    assign issue_last_o = issue_i && at_end;
    assign rd_addr_o    = {ch_q, samp_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_q   <= '0;
            samp_q <= '0;
        end else if (issue_i) begin
            if (samp_wrap) begin
                samp_q <= '0;
                ch_q   <= at_end ? '0 : ch_q + 1'b1;
            end else begin
                samp_q <= samp_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_o <= '0;
        end else begin
            tag_o.vld  <= issue_i;
            tag_o.last <= issue_last_o;
            tag_o.ch   <= ch_q;
            tag_o.samp <= samp_q;
        end
    end

    // R5: inside a channel, consecutive tags step the sample index by one
    assert_sample_step_R5: assert property (@(posedge clk) disable iff (rst)
        (tag_o.vld && $past(tag_o.vld) && ($past(tag_o.samp) != SAMP_LAST))
        |-> (tag_o.samp == $past(tag_o.samp) + 1'b1) && (tag_o.ch == $past(tag_o.ch)));

    // R5: a channel change starts again at sample zero
    assert_channel_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (tag_o.vld && $past(tag_o.vld) && (tag_o.ch != $past(tag_o.ch)))
        |-> (tag_o.samp == '0));

endmodule

// File: rtl/rdo_pack.sv
module rdo_pack
    import rdo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rd_tag_t           tag_i,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic              rd_err_i,
    output host_word_t        word_o,
    output logic              valid_o,
    output logic              last_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_o  <= '0;
            valid_o <= 1'b0;
            last_o  <= 1'b0;
        end else begin
            valid_o <= tag_i.vld;
            last_o  <= tag_i.vld && tag_i.last;
            word_o  <= tag_i.vld ? make_word(rd_err_i, tag_i.ch, tag_i.samp, rd_data_i)
                                 : '0;
        end
    end

    // R6: a word's tags come from the read that preceded it
    assert_tag_follows_R6: assert property (@(posedge clk) disable iff (rst)
        $past(tag_i.vld) |-> (word_o.ch == $past(tag_i.ch)) && (word_o.samp == $past(tag_i.samp)));

endmodule

// File: rtl/rdo_engine.sv
module rdo_engine
    import rdo_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int NUM_SAMP = 1024
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     capture_done_i,
    input  logic                     host_accept_i,
    output logic                     mem_rd_en_o,
    output logic [rdo_pkg::ADDR_W-1:0] mem_rd_addr_o,
    input  logic [rdo_pkg::DATA_W-1:0] mem_rd_data_i,
    input  logic                     mem_rd_err_i,
    output logic                     host_req_o,
    output logic                     word_valid_o,
    output logic [rdo_pkg::WORD_W-1:0] host_word_o,
    output logic                     bus_oe_o,
    output logic                     readout_done_o
);

    logic       issue;
    logic       issue_last;
    logic       out_last;
    rd_tag_t    tag;
    host_word_t word;

    rdo_ctrl u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .capture_done_i (capture_done_i),
        .host_accept_i  (host_accept_i),
        .issue_last_i   (issue_last),
        .out_last_i     (out_last),
        .issue_o        (issue),
        .req_o          (host_req_o),
        .oe_o           (bus_oe_o),
        .done_o         (readout_done_o)
    );

    rdo_addr #(
        .NUM_CH   (NUM_CH),
        .NUM_SAMP (NUM_SAMP)
    ) u_addr (
        .clk          (clk),
        .rst          (rst),
        .issue_i      (issue),
        .rd_addr_o    (mem_rd_addr_o),
        .issue_last_o (issue_last),
        .tag_o        (tag)
    );

    rdo_pack u_pack (
        .clk       (clk),
        .rst       (rst),
        .tag_i     (tag),
        .rd_data_i (mem_rd_data_i),
        .rd_err_i  (mem_rd_err_i),
        .word_o    (word),
        .valid_o   (word_valid_o),
        .last_o    (out_last)
    );

    assign mem_rd_en_o = issue;
    assign host_word_o = word;

    // R10: a valid word only appears while this module owns the bus
    assert_valid_owns_bus_R10: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |-> (bus_oe_o && host_req_o));

    // R10: idle word lines are quiet
    assert_quiet_lines_R10: assert property (@(posedge clk) disable iff (rst)
        !word_valid_o |-> (host_word_o == '0));

    // R7: every valid word has even parity
    assert_even_parity_R7: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |-> (^host_word_o == 1'b0));

    // R11: completion is a single-cycle pulse
    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        readout_done_o |=> !readout_done_o);

    // R2: the request only falls together with the completion pulse
    assert_req_falls_at_done_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(host_req_o) |-> readout_done_o);

    // R3: without a request the bus stays released in the next cycle
    assert_no_req_no_bus_R3: assert property (@(posedge clk) disable iff (rst)
        !host_req_o |=> !bus_oe_o);

endmodule

// File: tb/tb_rdo_engine.sv
module tb_rdo_engine;
    import rdo_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 8;
    localparam int NUM_SAMP   = 1024;
    localparam int N_WORDS    = NUM_CH * NUM_SAMP;

    logic                clk = 1'b0;
    logic                rst;
    logic                capture_done;
    logic                host_accept;
    logic                mem_rd_en;
    logic [ADDR_W-1:0]   mem_rd_addr;
    logic [DATA_W-1:0]   mem_rd_data;
    logic                mem_rd_err;
    logic                host_req;
    logic                word_valid;
    logic [WORD_W-1:0]   host_word;
    logic                bus_oe;
    logic                readout_done;

    int n_checks = 0;
    int n_fails  = 0;
    int mode     = 0;
    int salt     = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rdo_engine #(.NUM_CH(NUM_CH), .NUM_SAMP(NUM_SAMP)) dut (
        .clk            (clk),
        .rst            (rst),
        .capture_done_i (capture_done),
        .host_accept_i  (host_accept),
        .mem_rd_en_o    (mem_rd_en),
        .mem_rd_addr_o  (mem_rd_addr),
        .mem_rd_data_i  (mem_rd_data),
        .mem_rd_err_i   (mem_rd_err),
        .host_req_o     (host_req),
        .word_valid_o   (word_valid),
        .host_word_o    (host_word),
        .bus_oe_o       (bus_oe),
        .readout_done_o (readout_done)
    );

    function automatic logic [DATA_W-1:0] sample_val(int a);
        case (mode)
            1:       return '1;
            2:       return '0;
            default: return DATA_W'((a * 37 + salt) ^ (a >>> 3));
        endcase
    endfunction

    function automatic logic sample_err(int a);
        case (mode)
            1:       return 1'b1;
            2:       return 1'b0;
            default: return ((a * 13 + salt) % 17) == 0;
        endcase
    endfunction

    // word expected from R6, R7, R8: {err, ch, sample, value, parity}
    function automatic logic [WORD_W-1:0] exp_word(int ch, int s);
        logic [WORD_W-1:0] w;
        int a = ch * NUM_SAMP + s;
        w = {sample_err(a), CH_W'(ch), SAMP_W'(s), sample_val(a), 1'b0};
        w[0] = ^w[WORD_W-1:1];
        return w;
    endfunction

    // sample memory model, one cycle read latency (R9 addressing {ch, sample})
    always_ff @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= sample_val(int'(mem_rd_addr[ADDR_W-1:SAMP_W]) * NUM_SAMP
                                      + int'(mem_rd_addr[SAMP_W-1:0]));
            mem_rd_err  <= sample_err(int'(mem_rd_addr[ADDR_W-1:SAMP_W]) * NUM_SAMP
                                      + int'(mem_rd_addr[SAMP_W-1:0]));
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctl_bits();
        return {27'd0, host_req, word_valid, bus_oe, readout_done, mem_rd_en};
    endfunction

    task automatic run_readout(input int m, input int s, input int wait_cycles);
        logic [31:0] exp;
        mode = m;
        salt = s;
        @(negedge clk);
        capture_done = 1'b1;
        @(negedge clk);
        capture_done = 1'b0;
        // R2: request raised, nothing on the bus yet
        chk(ctl_bits() == 32'b10000, "R2 request after capture_done", ctl_bits(), 32'b10000);
        for (int k = 0; k < wait_cycles; k++) begin
            @(negedge clk);
            chk(ctl_bits() == 32'b10000, "R3 waiting for accept", ctl_bits(), 32'b10000);
        end
        host_accept = 1'b1;
        @(negedge clk);
        host_accept = 1'b0;
        // R4: bus enabled right after accept, no word yet
        chk(bus_oe && !word_valid, "R4 bus enable after accept",
            {30'd0, bus_oe, word_valid}, 32'b10);
        @(negedge clk);
        chk(!word_valid && host_word == '0, "R4 R10 no word yet",
            {6'd0, word_valid, host_word}, 32'd0);
        for (int i = 0; i < N_WORDS; i++) begin
            @(negedge clk);
            exp = {6'd0, 1'b1, exp_word(i / NUM_SAMP, i % NUM_SAMP)};
            chk({6'd0, word_valid, host_word} == exp, "R5 R6 R8 R9 word",
                {6'd0, word_valid, host_word}, exp);
            chk(^host_word == 1'b0, "R7 parity", {7'd0, host_word}, exp);
            chk(bus_oe && host_req && !readout_done, "R2 R10 ownership during transfer",
                ctl_bits(), 32'b11100);
            if (i == 100) begin
                capture_done = 1'b1;
                host_accept  = 1'b1;
            end else begin
                capture_done = 1'b0;
                host_accept  = 1'b0;
            end
        end
        @(negedge clk);
        // R11: end of transfer
        chk(ctl_bits() == 32'b00010 && host_word == '0, "R11 completion pulse",
            ctl_bits(), 32'b00010);
        @(negedge clk);
        chk(ctl_bits() == 32'b00000, "R11 pulse is one cycle", ctl_bits(), 32'b00000);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(ctl_bits() == 32'b00000, "R12 no request from ignored pulse",
                ctl_bits(), 32'b00000);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog (R5 R11): actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d5e));
        rst          = 1'b1;
        capture_done = 1'b0;
        host_accept  = 1'b0;
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk(ctl_bits() == 32'd0 && host_word == '0, "R1 reset state", ctl_bits(), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(ctl_bits() == 32'd0 && host_word == '0, "R1 after reset", ctl_bits(), 32'd0);

        // R3: accept while idle is ignored
        host_accept = 1'b1;
        @(negedge clk);
        host_accept = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(ctl_bits() == 32'd0, "R3 accept ignored when idle", ctl_bits(), 32'd0);
        end

        run_readout(0, int'($urandom % 1000), 3);
        run_readout(1, 0, 0);
        run_readout(2, 0, 7);
        run_readout(0, int'($urandom % 1000) + 1000, int'($urandom % 5));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule